// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a small, fully associative translation buffer. Each entry maps two neighbouring virtual pages, an even one and an odd one, onto two independent physical frames. Both pages share one tag, one address-space identifier and one page size. A lookup request carries a virtual address, the current address-space identifier and an access kind. One cycle later the block returns a physical address and a result code. The code tells the surrounding pipeline whether the access may go ahead or which kind of translation fault to raise.

Entries are loaded through a single write port that addresses one slot by index. Each entry has a page-size mask. Bits set in the mask are left out of the tag compare, which makes the page pair larger. The mask is always widened to cover at least the smallest pair span. The bit just above the half-span picks the even or the odd page. Each page has its own valid, dirty, read-inhibit and execute-inhibit bits, and these are checked against the access kind.

Top module: `pp_tlb`

## Requirements
- R1: After reset, `rsp_valid_o` is 0. Every entry has both valid bits cleared and its invalidate flag set, so any lookup returns no-match.
- R2: `rsp_valid_o` is 1 in exactly the cycle after a cycle with `req_i` high. `res_o` and `pa_o` change only at those edges and hold their values otherwise.
- R3: An entry hits when all three of these hold: its invalidate flag is clear; its global bit is set or its identifier equals `asid_i`; and its stored virtual tag equals `va_i` with the effective-mask bits ignored in both.
- R4: The effective mask is the written mask ORed with 2^(PG_BITS+1)-1. Mask bits below that span have no effect.
- R5: The odd page is chosen when `va_i` has a 1 at the highest bit of the effective mask. On a match, `pa_o` = the chosen page's frame value ORed with the `va_i` bits below that bit.
- R6: If the chosen page's valid bit (flag bit 3) is 0, the result is invalid (code 2) for every access kind.
- R7: A fetch (`acc_i`=0) to a page with execute-inhibit (flag bit 0) set returns code 5.
- R8: A load (`acc_i`=1) to a page with read-inhibit (flag bit 1) set returns code 4.
- R9: A store (`acc_i`=2) to a page with dirty (flag bit 2) clear returns modified (code 3). Otherwise a valid access with no inhibit that applies returns match (code 0). The checks are made in the order valid, execute-inhibit, read-inhibit, dirty.
- R10: When no entry hits, the result is no-match (code 1).
- R11: When several entries hit, the entry with the lowest index gives the result.
- R12: `pa_o` is 0 whenever the registered result is not match.
- R13: A write is visible to lookups from the following cycle. A lookup made in the same cycle as a write to the entry it hits sees the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup strobe |
| va_i | input | VA_W | Virtual address to translate |
| asid_i | input | ASID_W | Current address-space identifier |
| acc_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | IDX_W | Entry slot to write |
| wr_vpn_i | input | VA_W | Virtual tag, in address form |
| wr_mask_i | input | VA_W | Page-size mask, in address form |
| wr_asid_i | input | ASID_W | Entry identifier |
| wr_g_i | input | 1 | Global bit |
| wr_inv_i | input | 1 | Invalidate flag |
| wr_pfn0_i | input | PA_W | Even-page frame, in address form |
| wr_pfn1_i | input | PA_W | Odd-page frame, in address form |
| wr_fl0_i | input | 4 | Even-page flags {valid, dirty, read-inhibit, execute-inhibit} |
| wr_fl1_i | input | 4 | Odd-page flags, same layout |
| rsp_valid_o | output | 1 | Response strobe |
| res_o | output | 3 | Result code |
| pa_o | output | PA_W | Physical address |

## Verification
An entry write and a lookup can land in the same cycle. When both target one slot, the lookup has to be answered from the contents held before that clock edge. The bench drives both strobes on one negative edge with a new frame for the slot being looked up. It expects the old frame in that response and the new frame in the lookup that follows. Every other cycle is judged against a reference kept in the bench, which holds the entries and applies the stated hit, select and check rules.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef enum logic [2:0] {
    RES_MATCH    = 3'd0,
    RES_NOMATCH  = 3'd1,
    RES_INVALID  = 3'd2,
    RES_MODIFIED = 3'd3,
    RES_RINH     = 3'd4,
    RES_XINH     = 3'd5
  } res_e;

  typedef struct packed {
    logic v;
    logic d;
    logic ri;
    logic xi;
  } pflags_t;
endpackage

// File: rtl/ppt_store.sv
module ppt_store
  import ppt_pkg::*;
#(
  parameter int N      = 16,
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_idx_i,
  input  logic [VA_W-1:0]               wr_vpn_i,
  input  logic [VA_W-1:0]               wr_mask_i,
  input  logic [ASID_W-1:0]             wr_asid_i,
  input  logic                          wr_g_i,
  input  logic                          wr_inv_i,
  input  logic [PA_W-1:0]               wr_pfn0_i,
  input  logic [PA_W-1:0]               wr_pfn1_i,
  input  pflags_t                       wr_fl0_i,
  input  pflags_t                       wr_fl1_i,
  output logic [N-1:0][VA_W-1:0]        vpn_o,
  output logic [N-1:0][VA_W-1:0]        mask_o,
  output logic [N-1:0][ASID_W-1:0]      asid_o,
  output logic [N-1:0]                  g_o,
  output logic [N-1:0]                  inv_o,
  output logic [N-1:0][PA_W-1:0]        pfn0_o,
  output logic [N-1:0][PA_W-1:0]        pfn1_o,
  output pflags_t [N-1:0]               fl0_o,
  output pflags_t [N-1:0]               fl1_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    wire sel = wr_en_i && (wr_idx_i == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_o[i]  <= '0;
        mask_o[i] <= '0;
        asid_o[i] <= '0;
        g_o[i]    <= 1'b0;
        inv_o[i]  <= 1'b1;
        pfn0_o[i] <= '0;
        pfn1_o[i] <= '0;
        fl0_o[i]  <= '0;
        fl1_o[i]  <= '0;
      end else if (sel) begin
        vpn_o[i]  <= wr_vpn_i;
        mask_o[i] <= wr_mask_i;
        asid_o[i] <= wr_asid_i;
        g_o[i]    <= wr_g_i;
        inv_o[i]  <= wr_inv_i;
        pfn0_o[i] <= wr_pfn0_i;
        pfn1_o[i] <= wr_pfn1_i;
        fl0_o[i]  <= wr_fl0_i;
        fl1_o[i]  <= wr_fl1_i;
      end
    end
  end

  // R13
  wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vpn_o[$past(wr_idx_i)] == $past(wr_vpn_i))
             && (pfn1_o[$past(wr_idx_i)] == $past(wr_pfn1_i)));
endmodule

// File: rtl/ppt_match.sv
module ppt_match
  import ppt_pkg::*;
#(
  parameter int N       = 16,
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int PG_BITS = 12
) (
  input  logic [VA_W-1:0]               va_i,
  input  logic [ASID_W-1:0]             asid_i,
  input  logic [N-1:0][VA_W-1:0]        vpn_i,
  input  logic [N-1:0][VA_W-1:0]        mask_i,
  input  logic [N-1:0][ASID_W-1:0]      ent_asid_i,
  input  logic [N-1:0]                  g_i,
  input  logic [N-1:0]                  inv_i,
  output logic [N-1:0]                  hit_o,
  output logic [N-1:0]                  odd_o,
  output logic [N-1:0][VA_W-1:0]        emask_o
);
  localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << (PG_BITS + 1)) - 64'd1);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [VA_W-1:0] em;
    assign em         = mask_i[i] | MIN_MASK;
    assign emask_o[i] = em;
    assign hit_o[i]   = !inv_i[i]
                     && (g_i[i] || (ent_asid_i[i] == asid_i))
                     && ((va_i & ~em) == (vpn_i[i] & ~em));
    // selector bit: inside mask, outside half-mask
    assign odd_o[i]   = |(va_i & em & ~(em >> 1));
  end
endmodule

// File: rtl/ppt_resolve.sv
module ppt_resolve
  import ppt_pkg::*;
#(
  parameter int N    = 16,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [VA_W-1:0]               va_i,
  input  acc_e                          acc_i,
  input  logic [N-1:0]                  hit_i,
  input  logic [N-1:0]                  odd_i,
  input  logic [N-1:0][VA_W-1:0]        emask_i,
  input  logic [N-1:0][PA_W-1:0]        pfn0_i,
  input  logic [N-1:0][PA_W-1:0]        pfn1_i,
  input  pflags_t [N-1:0]               fl0_i,
  input  pflags_t [N-1:0]               fl1_i,
  output logic [N-1:0]                  grant_o,
  output res_e                          res_o,
  output logic [PA_W-1:0]               pa_o
);
  logic             any;
  logic [IDX_W-1:0] sel;
  pflags_t          fl;
  logic [PA_W-1:0]  pfn;
  logic [VA_W-1:0]  half;

  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign grant_o = any ? (N'(1) << sel) : '0;
  assign fl      = odd_i[sel] ? fl1_i[sel]  : fl0_i[sel];
  assign pfn     = odd_i[sel] ? pfn1_i[sel] : pfn0_i[sel];
  assign half    = emask_i[sel] >> 1;

  always_comb begin
    if (!any)                             res_o = RES_NOMATCH;
    else if (!fl.v)                       res_o = RES_INVALID;
    else if (acc_i == ACC_FETCH && fl.xi) res_o = RES_XINH;
    else if (acc_i == ACC_LOAD  && fl.ri) res_o = RES_RINH;
    else if (acc_i == ACC_STORE && !fl.d) res_o = RES_MODIFIED;
    else                                  res_o = RES_MATCH;
  end

  assign pa_o = (res_o == RES_MATCH) ? (pfn | PA_W'(va_i & half)) : '0;
endmodule

// File: rtl/pp_tlb.sv
module pp_tlb
  import ppt_pkg::*;
#(
  parameter int N       = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int PG_BITS = 12,
  localparam int IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [1:0]        acc_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VA_W-1:0]   wr_vpn_i,
  input  logic [VA_W-1:0]   wr_mask_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_g_i,
  input  logic              wr_inv_i,
  input  logic [PA_W-1:0]   wr_pfn0_i,
  input  logic [PA_W-1:0]   wr_pfn1_i,
  input  logic [3:0]        wr_fl0_i,
  input  logic [3:0]        wr_fl1_i,
  output logic              rsp_valid_o,
  output logic [2:0]        res_o,
  output logic [PA_W-1:0]   pa_o
);
  logic [N-1:0][VA_W-1:0]   vpn, mask, emask;
  logic [N-1:0][ASID_W-1:0] e_asid;
  logic [N-1:0]             g, inv, hit, odd, grant;
  logic [N-1:0][PA_W-1:0]   pfn0, pfn1;
  pflags_t [N-1:0]          fl0, fl1;
  res_e                     res_d, res_q;
  logic [PA_W-1:0]          pa_d;

  ppt_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_vpn_i, .wr_mask_i, .wr_asid_i,
    .wr_g_i, .wr_inv_i, .wr_pfn0_i, .wr_pfn1_i,
    .wr_fl0_i(pflags_t'(wr_fl0_i)), .wr_fl1_i(pflags_t'(wr_fl1_i)),
    .vpn_o(vpn), .mask_o(mask), .asid_o(e_asid), .g_o(g), .inv_o(inv),
    .pfn0_o(pfn0), .pfn1_o(pfn1), .fl0_o(fl0), .fl1_o(fl1));

  ppt_match #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W), .PG_BITS(PG_BITS)) u_match (
    .va_i, .asid_i, .vpn_i(vpn), .mask_i(mask), .ent_asid_i(e_asid),
    .g_i(g), .inv_i(inv), .hit_o(hit), .odd_o(odd), .emask_o(emask));

  ppt_resolve #(.N(N), .VA_W(VA_W), .PA_W(PA_W)) u_resolve (
    .va_i, .acc_i(acc_e'(acc_i)), .hit_i(hit), .odd_i(odd), .emask_i(emask),
    .pfn0_i(pfn0), .pfn1_i(pfn1), .fl0_i(fl0), .fl1_i(fl1),
    .grant_o(grant), .res_o(res_d), .pa_o(pa_d));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      res_q       <= RES_NOMATCH;
      pa_o        <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        res_q <= res_d;
        pa_o  <= pa_d;
      end
    end
  end
  assign res_o = res_q;

  // R11
  grant_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && ((grant & ~hit) == '0) && (((grant - N'(1)) & hit) == '0)
    && ((hit != '0) == (grant != '0)));
  // R10
  nomatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hit == '0) |=> (res_o == RES_NOMATCH));
  // R12
  pa_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && res_o != RES_MATCH) |-> (pa_o == '0));
  // R9
  modified_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_i != ACC_STORE) |=> (res_o != RES_MODIFIED));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && $stable(res_o) && $stable(pa_o)));
endmodule

// File: tb/pp_tlb_tb.sv
module pp_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, wr_en = 1'b0, wr_g = 1'b0, wr_inv = 1'b0;
  logic [31:0] va = '0, wr_vpn = '0, wr_mask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
  logic [7:0]  asid = '0, wr_asid = '0;
  logic [1:0]  acc = '0;
  logic [3:0]  wr_idx = '0, wr_fl0 = '0, wr_fl1 = '0;
  logic        rsp_valid;
  logic [2:0]  res;
  logic [31:0] pa;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  logic [31:0] m_vpn[N], m_mask[N], m_p0[N], m_p1[N];
  logic [7:0]  m_asid[N];
  logic        m_g[N], m_inv[N];
  logic [3:0]  m_f0[N], m_f1[N];

  pp_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va), .asid_i(asid), .acc_i(acc),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vpn_i(wr_vpn), .wr_mask_i(wr_mask),
    .wr_asid_i(wr_asid), .wr_g_i(wr_g), .wr_inv_i(wr_inv), .wr_pfn0_i(wr_pfn0),
    .wr_pfn1_i(wr_pfn1), .wr_fl0_i(wr_fl0), .wr_fl1_i(wr_fl1),
    .rsp_valid_o(rsp_valid), .res_o(res), .pa_o(pa));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference: minimum pair span 8K, checks in order valid, xi, ri, dirty
  function automatic void model(input logic [31:0] a, input logic [7:0] id, input logic [1:0] k,
                                output logic [2:0] r, output logic [31:0] p);
    r = 3'd1; p = '0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] em;
      logic        od;
      logic [3:0]  f;
      em = m_mask[i] | 32'h1FFF;
      if (!m_inv[i] && (m_g[i] || m_asid[i] == id) && ((a & ~em) == (m_vpn[i] & ~em))) begin
        od = |(a & em & ~(em >> 1));
        f  = od ? m_f1[i] : m_f0[i];
        if (!f[3])                r = 3'd2;
        else if (k == 2'd0 && f[0]) r = 3'd5;
        else if (k == 2'd1 && f[1]) r = 3'd4;
        else if (k == 2'd2 && !f[2]) r = 3'd3;
        else begin
          r = 3'd0;
          p = (od ? m_p1[i] : m_p0[i]) | (a & (em >> 1));
        end
        return;
      end
    end
  endfunction

  task automatic model_wr(input int i, input logic [31:0] v, input logic [31:0] mk, input logic [7:0] id,
                          input logic gg, input logic iv, input logic [31:0] p0, input logic [31:0] p1,
                          input logic [3:0] f0, input logic [3:0] f1);
    m_vpn[i] = v; m_mask[i] = mk; m_asid[i] = id; m_g[i] = gg; m_inv[i] = iv;
    m_p0[i] = p0; m_p1[i] = p1; m_f0[i] = f0; m_f1[i] = f1;
  endtask

  task automatic set_wr(input int i, input logic [31:0] v, input logic [31:0] mk, input logic [7:0] id,
                        input logic gg, input logic iv, input logic [31:0] p0, input logic [31:0] p1,
                        input logic [3:0] f0, input logic [3:0] f1);
    wr_en = 1'b1; wr_idx = 4'(i); wr_vpn = v; wr_mask = mk; wr_asid = id; wr_g = gg;
    wr_inv = iv; wr_pfn0 = p0; wr_pfn1 = p1; wr_fl0 = f0; wr_fl1 = f1;
  endtask

  task automatic wr(input int i, input logic [31:0] v, input logic [31:0] mk, input logic [7:0] id,
                    input logic gg, input logic iv, input logic [31:0] p0, input logic [31:0] p1,
                    input logic [3:0] f0, input logic [3:0] f1);
    @(negedge clk);
    set_wr(i, v, mk, id, gg, iv, p0, p1, f0, f1);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(i, v, mk, id, gg, iv, p0, p1, f0, f1);
  endtask

  task automatic look(input logic [31:0] a, input logic [7:0] id, input logic [1:0] k, input string tag);
    logic [2:0]  er;
    logic [31:0] ep;
    model(a, id, k, er, ep);
    @(negedge clk);
    req = 1'b1; va = a; asid = id; acc = k;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " res"}, 32'(res), 32'(er));
    chk({tag, " pa"}, pa, ep);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model_wr(i, '0, '0, '0, 1'b0, 1'b1, '0, '0, '0, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    look(32'h0000_0000, 8'd0, 2'd1, "R1 empty lookup");
    look(32'h7FFF_E123, 8'd0, 2'd2, "R1 empty lookup hi");
    @(negedge clk);
    chk("R2 rsp_valid idle", 32'(rsp_valid), 32'd0);
    chk("R2 res held", 32'(res), 32'd1);

    // R6 R7 R8 R9 R5 R12: full flag sweep, both halves, all access kinds
    for (int f = 0; f < 16; f++) begin
      wr(3, 32'h0040_0000, 32'h0, 8'd5, 1'b0, 1'b0, 32'h0012_3000, 32'h0045_6000,
         4'(f), ~4'(f));
      for (int k = 0; k < 3; k++)
        for (int h = 0; h < 2; h++)
          look(32'h0040_05A4 | (32'(h) << 12), 8'd5, 2'(k), "R6/R7/R8/R9 flag sweep");
    end

    // R3: identifier, global and invalidate combinations
    for (int gg = 0; gg < 2; gg++)
      for (int iv = 0; iv < 2; iv++)
        for (int am = 0; am < 2; am++) begin
          wr(4, 32'h0100_0000, 32'h0, 8'h33, 1'(gg), 1'(iv), 32'h00A0_0000, 32'h00B0_0000,
             4'b1100, 4'b1100);
          look(32'h0100_1010, am ? 8'h33 : 8'h34, 2'd1, "R3 asid/global/inv");
        end
    look(32'h0100_4010, 8'h33, 2'd1, "R3 tag mismatch");

    // R4 R5: page-mask sweep; sub-minimum mask bits ignored
    for (int k = 0; k < 5; k++) begin
      logic [31:0] m, hf;
      m  = (32'd1 << (13 + 2 * k)) - 32'd1;
      hf = m >> 1;
      wr(6, 32'h4000_0777, (k == 0) ? 32'h0000_03FF : m, 8'd1, 1'b0, 1'b0,
         32'h0800_0000, 32'h0900_0000, 4'b1100, 4'b1000);
      look(32'h4000_0005, 8'd1, 2'd1, "R4 mask even low");
      look(32'h4000_0005 | (hf + 1), 8'd1, 2'd1, "R5 mask odd low");
      look(32'h4000_0000 | m, 8'd1, 2'd2, "R5 mask odd top store");
      look(32'h4000_0000 + m + 1, 8'd1, 2'd1, "R4 outside span");
    end

    // R11: lowest index wins
    wr(9, 32'h2000_0000, 32'h0, 8'd7, 1'b0, 1'b0, 32'h0090_0000, 32'h0091_0000, 4'b1100, 4'b1100);
    wr(2, 32'h2000_0000, 32'h0, 8'd7, 1'b1, 1'b0, 32'h0020_0000, 32'h0021_0000, 4'b1100, 4'b1100);
    look(32'h2000_0ABC, 8'd7, 2'd1, "R11 lowest index");
    chk("R11 entry 2 frame", pa, 32'h0020_0ABC);
    wr(2, 32'h2000_0000, 32'h0, 8'd7, 1'b1, 1'b1, 32'h0020_0000, 32'h0021_0000, 4'b1100, 4'b1100);
    look(32'h2000_1ABC, 8'd7, 2'd0, "R11 fallback");
    chk("R11 entry 9 frame", pa, 32'h0091_0ABC);
    look(32'h2000_1ABC, 8'd8, 2'd0, "R10 wrong asid");

    // R13: write and lookup in the same cycle
    wr(5, 32'h0070_0000, 32'h0, 8'd2, 1'b0, 1'b0, 32'h0300_0000, 32'h0310_0000, 4'b1100, 4'b1100);
    @(negedge clk);
    set_wr(5, 32'h0070_0000, 32'h0, 8'd2, 1'b0, 1'b0, 32'h0500_0000, 32'h0510_0000, 4'b1100, 4'b1100);
    req = 1'b1; va = 32'h0070_0044; asid = 8'd2; acc = 2'd1;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    chk("R13 same-cycle res", 32'(res), 32'd0);
    chk("R13 same-cycle old frame", pa, 32'h0300_0044);
    model_wr(5, 32'h0070_0000, 32'h0, 8'd2, 1'b0, 1'b0, 32'h0500_0000, 32'h0510_0000, 4'b1100, 4'b1100);
    look(32'h0070_0044, 8'd2, 2'd1, "R13 next lookup");
    chk("R13 new frame", pa, 32'h0500_0044);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule